// File: doc/BRIEF.md
# Prescaled Three-Channel Interval Timer

This block holds three down-counting timers fed from one shared oscillator enable. Each timer has its own fixed prescaler: timer 0 advances once per 10 oscillator ticks, timers 1 and 2 once per 1000. Timer 0 paces individual conversions and timer 1 paces scan starts. Timer 2 is a general 24-bit timer whose terminal count latches a sticky interrupt flag.

Software reaches the timers through a byte-wide select register and a 16-bit data port. The low nibble of the select register picks which timer, or which half of timer 2, the port addresses. Its high nibble drives four general outputs. A packed mode register gives each timer a 2-bit counting mode. Gate bits in a 16-bit control word let each timer count.

Each timer runs a small state machine with four states. IDLE means never loaded, or a software strobe has finished. RUN means counting down. ARMED means waiting for a hardware trigger. DONE means a single terminal count has ended. The transitions are:
- load: any state to RUN, or to ARMED in hardware-strobe mode.
- fire: RUN to RUN (rate generator), to ARMED (hardware strobe), to DONE (single terminal count) or to IDLE (software strobe).
- trigger: ARMED to RUN.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset all counts read 0, every `tc_pulse` bit is 0, `t2_irq` is 0, `dout` is 0 and `sel_rdata` is 0.
- R2: A gated timer decrements once per prescaler period of oscillator ticks: 10 for timer 0, 1000 for timers 1 and 2. The prescaler restarts on each load. While `osc_tick` is low, no count changes.
- R3: Mode 1 (rate generator) emits a one-clock `tc_pulse` every N×prescale cycles and reloads N automatically, where N is the loaded value.
- R4: Mode 0 (single terminal count) emits one pulse after N×prescale cycles. The count then stays at 0 with no further pulses.
- R5: Mode 2 (software strobe) runs one cycle per write and ends in exactly one strobe, after which the count reads N again. A new write during a cycle restarts timing from that write.
- R6: Mode 3 (hardware strobe) waits after a load without counting. A `hw_trig` bit high while gated starts a cycle that strobes N×prescale cycles later, and the timer re-arms with N.
- R7: Control bits 12, 13 and 14 gate timers 0, 1 and 2. With its gate low a timer's count is frozen and it emits no pulse. All other control bits have no effect.
- R8: A loaded value of 0 or 1 is taken as 2.
- R9: Select code (bits [3:0]) 0, 1 or 2 addresses timer 0, 1 or the low 16 bits of timer 2, and code 3 addresses the upper 8 bits of timer 2. `port_rdata` returns the addressed count. Codes 4–15 ignore port writes and read 0.
- R10: A code-2 write only stages the low half of timer 2. The next code-3 write loads `{port_wdata[7:0], staged}` in one step.
- R11: `dout` equals select bits [7:4], and `sel_rdata` returns the whole select byte.
- R12: A timer-2 terminal pulse sets `t2_irq` one cycle later. The flag stays set until a `sel_rd_en` cycle clears it.
- R13: Mode field for timer n sits at bits [2n+1:2n] of the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Base oscillator enable |
| sel_wr_en | input | 1 | Write select register |
| sel_rd_en | input | 1 | Select register read strobe (clears flag) |
| sel_wdata | input | 8 | Select write data |
| sel_rdata | output | 8 | Select register contents |
| mode_wr_en | input | 1 | Write mode register |
| mode_wdata | input | 8 | Packed mode fields |
| ctrl_wr_en | input | 1 | Write control word |
| ctrl_wdata | input | 16 | Control word (gates at 14:12) |
| port_wr_en | input | 1 | Write data port |
| port_wdata | input | 16 | Data port write value |
| port_rdata | output | 16 | Count of addressed target |
| hw_trig | input | 3 | Hardware triggers, one per timer |
| tc_pulse | output | 3 | Terminal-count pulses, one per timer |
| t2_irq | output | 1 | Sticky timer-2 flag |
| dout | output | 4 | General outputs from select bits 7:4 |

## Verification
Each mode is driven with small reload values, and the cycle of every pulse is measured from the loading write. This separates correct prescaler ratios and reload handling from off-by-one errors. A restart write in the middle of a cycle, a trigger-then-idle sequence and a gate held low each show whether a cycle starts only from its intended cause. Reload values 0 and 1, an invalid select code and a lone low-half write to timer 2 are read back through the data port, which shows clamping, ignored writes and staging. A timer-1 run with mode field 1 confirms both the field position and the 1000 divider.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NTMR = 3;
    localparam int GATE_LSB = 12;

    typedef enum logic [1:0] {
        M_TERM  = 2'd0,
        M_RATE  = 2'd1,
        M_SWSTB = 2'd2,
        M_HWSTB = 2'd3
    } tmode_e;

    typedef enum logic [1:0] {
        T_IDLE,
        T_RUN,
        T_ARMED,
        T_DONE
    } tstate_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic clear,
    output logic tick
);
    localparam int PW = (PRE > 1) ? $clog2(PRE) : 1;

    logic [PW-1:0] pre_q;

    assign tick = osc_tick && (pre_q == PW'(PRE - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)        pre_q <= '0;
        else if (clear)    pre_q <= '0;
        else if (tick)     pre_q <= '0;
        else if (osc_tick) pre_q <= pre_q + 1'b1;
    end

    // R2
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pre_q) < PRE);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW  = 16,
    parameter int PRE = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          osc_tick,
    input  logic          gate,
    input  tmode_e        mode,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          hw_trig,
    output logic [CW-1:0] count,
    output logic          tc
);
    tstate_e st_q, st_d;
    logic          tick;
    logic          fire;
    logic          trig_start;
    logic          pre_clr;
    logic [CW-1:0] reload_q;
    logic [CW-1:0] clamped;

    assign clamped    = (load_val < CW'(2)) ? CW'(2) : load_val;
    assign trig_start = (st_q == T_ARMED) && gate && hw_trig;
    assign fire       = (st_q == T_RUN) && gate && tick && (count == CW'(1));
    assign pre_clr    = load || trig_start;

    tmr_prescaler #(.PRE(PRE)) i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .clear    (pre_clr),
        .tick     (tick)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d = (mode == M_HWSTB) ? T_ARMED : T_RUN;
        end else begin
            unique case (st_q)
                T_IDLE:  st_d = T_IDLE;
                T_RUN: begin
                    if (fire) begin
                        unique case (mode)
                            M_RATE:  st_d = T_RUN;
                            M_HWSTB: st_d = T_ARMED;
                            M_TERM:  st_d = T_DONE;
                            M_SWSTB: st_d = T_IDLE;
                        endcase
                    end
                end
                T_ARMED: if (trig_start) st_d = T_RUN;
                T_DONE:  st_d = T_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= T_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            reload_q <= '0;
            tc       <= 1'b0;
        end else begin
            tc <= fire;
            if (load) begin
                reload_q <= clamped;
                count    <= clamped;
            end else if (fire) begin
                count <= (mode == M_TERM) ? '0 : reload_q;
            end else if ((st_q == T_RUN) && gate && tick) begin
                count <= count - 1'b1;
            end
        end
    end

    // R3
    tc_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);
    // R7
    gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !load) |=> $stable(count));
    // R8
    run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_RUN) |-> (count != '0));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int PW = 16,
    parameter int WW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr_en,
    input  logic [7:0]        sel_wdata,
    input  logic              mode_wr_en,
    input  logic [7:0]        mode_wdata,
    input  logic              ctrl_wr_en,
    input  logic [15:0]       ctrl_wdata,
    input  logic              port_wr_en,
    input  logic [PW-1:0]     port_wdata,
    output logic [7:0]        sel_q,
    output logic [2*NTMR-1:0] mode_q,
    output logic [NTMR-1:0]   gate_q,
    output logic [NTMR-1:0]   load,
    output logic [WW-1:0]     load_val
);
    localparam int HI_W = WW - PW;

    logic [PW-1:0] stage_q;
    logic [3:0]    code;
    logic          unused_bits;

    assign code        = sel_q[3:0];
    assign unused_bits = ^{mode_wdata[7:2*NTMR], ctrl_wdata[GATE_LSB-1:0],
                           ctrl_wdata[15:GATE_LSB+NTMR]};

    always_comb begin
        load     = '0;
        load_val = WW'(port_wdata);
        if (port_wr_en) begin
            case (code)
                4'd0: load[0] = 1'b1;
                4'd1: load[1] = 1'b1;
                4'd3: begin
                    load[2]  = 1'b1;
                    load_val = {port_wdata[HI_W-1:0], stage_q};
                end
                default: load = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            mode_q  <= '0;
            gate_q  <= '0;
            stage_q <= '0;
        end else begin
            if (sel_wr_en)  sel_q  <= sel_wdata;
            if (mode_wr_en) mode_q <= mode_wdata[2*NTMR-1:0];
            if (ctrl_wr_en) gate_q <= ctrl_wdata[GATE_LSB +: NTMR];
            if (port_wr_en && (code == 4'd2)) stage_q <= port_wdata;
        end
    end

    // R10
    staged_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr_en && (code == 4'd2)) |-> (load == '0));
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import tmr_pkg::*;
#(
    parameter int PRE0 = 10,
    parameter int PRE1 = 1000,
    parameter int PRE2 = 1000,
    parameter int PW   = 16,
    parameter int WW   = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_tick,
    input  logic        sel_wr_en,
    input  logic        sel_rd_en,
    input  logic [7:0]  sel_wdata,
    output logic [7:0]  sel_rdata,
    input  logic        mode_wr_en,
    input  logic [7:0]  mode_wdata,
    input  logic        ctrl_wr_en,
    input  logic [15:0] ctrl_wdata,
    input  logic        port_wr_en,
    input  logic [15:0] port_wdata,
    output logic [15:0] port_rdata,
    input  logic [2:0]  hw_trig,
    output logic [2:0]  tc_pulse,
    output logic        t2_irq,
    output logic [3:0]  dout
);
    localparam int HI_W = WW - PW;

    logic [7:0]        sel_q;
    logic [2*NTMR-1:0] mode_q;
    logic [NTMR-1:0]   gate_q;
    logic [NTMR-1:0]   load;
    logic [WW-1:0]     load_val;
    logic [PW-1:0]     cnt_lo [NTMR];
    logic [HI_W-1:0]   cnt_hi;
    logic              irq_q;

    tmr_regs #(.PW(PW), .WW(WW)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_wr_en  (sel_wr_en),
        .sel_wdata  (sel_wdata),
        .mode_wr_en (mode_wr_en),
        .mode_wdata (mode_wdata),
        .ctrl_wr_en (ctrl_wr_en),
        .ctrl_wdata (ctrl_wdata),
        .port_wr_en (port_wr_en),
        .port_wdata (port_wdata),
        .sel_q      (sel_q),
        .mode_q     (mode_q),
        .gate_q     (gate_q),
        .load       (load),
        .load_val   (load_val)
    );

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        localparam int PRE = (i == 0) ? PRE0 : ((i == 1) ? PRE1 : PRE2);
        if (i == NTMR - 1) begin : g_wide
            logic [WW-1:0] c;
            tmr_channel #(.CW(WW), .PRE(PRE)) i_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .osc_tick (osc_tick),
                .gate     (gate_q[i]),
                .mode     (tmode_e'(mode_q[2*i +: 2])),
                .load     (load[i]),
                .load_val (load_val),
                .hw_trig  (hw_trig[i]),
                .count    (c),
                .tc       (tc_pulse[i])
            );
            assign cnt_lo[i] = c[PW-1:0];
            assign cnt_hi    = c[WW-1:PW];
        end else begin : g_narrow
            logic [PW-1:0] c;
            tmr_channel #(.CW(PW), .PRE(PRE)) i_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .osc_tick (osc_tick),
                .gate     (gate_q[i]),
                .mode     (tmode_e'(mode_q[2*i +: 2])),
                .load     (load[i]),
                .load_val (load_val[PW-1:0]),
                .hw_trig  (hw_trig[i]),
                .count    (c),
                .tc       (tc_pulse[i])
            );
            assign cnt_lo[i] = c;
        end
    end

    always_comb begin
        case (sel_q[3:0])
            4'd0:    port_rdata = cnt_lo[0];
            4'd1:    port_rdata = cnt_lo[1];
            4'd2:    port_rdata = cnt_lo[2];
            4'd3:    port_rdata = PW'(cnt_hi);
            default: port_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           irq_q <= 1'b0;
        else if (tc_pulse[2]) irq_q <= 1'b1;
        else if (sel_rd_en)   irq_q <= 1'b0;
    end

    assign t2_irq    = irq_q;
    assign sel_rdata = sel_q;
    assign dout      = sel_q[7:4];

    // R12
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t2_irq && !$past(t2_irq)) |-> $past(tc_pulse[2]));
endmodule

// File: tb/test_tri_interval_timer.sv
`timescale 1ns/1ps
module test_tri_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b1;
    logic        sel_wr_en = 1'b0, sel_rd_en = 1'b0;
    logic [7:0]  sel_wdata = '0;
    logic [7:0]  sel_rdata;
    logic        mode_wr_en = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic        ctrl_wr_en = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        port_wr_en = 1'b0;
    logic [15:0] port_wdata = '0;
    logic [15:0] port_rdata;
    logic [2:0]  hw_trig = '0;
    logic [2:0]  tc_pulse;
    logic        t2_irq;
    logic [3:0]  dout;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tri_interval_timer i_tri_interval_timer (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .sel_wr_en(sel_wr_en), .sel_rd_en(sel_rd_en), .sel_wdata(sel_wdata),
        .sel_rdata(sel_rdata), .mode_wr_en(mode_wr_en), .mode_wdata(mode_wdata),
        .ctrl_wr_en(ctrl_wr_en), .ctrl_wdata(ctrl_wdata),
        .port_wr_en(port_wr_en), .port_wdata(port_wdata), .port_rdata(port_rdata),
        .hw_trig(hw_trig), .tc_pulse(tc_pulse), .t2_irq(t2_irq), .dout(dout)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_sel(input logic [7:0] v);
        @(negedge clk); sel_wr_en = 1'b1; sel_wdata = v;
        @(negedge clk); sel_wr_en = 1'b0;
    endtask
    task automatic wr_mode(input logic [7:0] v);
        @(negedge clk); mode_wr_en = 1'b1; mode_wdata = v;
        @(negedge clk); mode_wr_en = 1'b0;
    endtask
    task automatic wr_ctrl(input logic [15:0] v);
        @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr_en = 1'b0;
    endtask
    task automatic wr_port(input logic [15:0] v);
        @(negedge clk); port_wr_en = 1'b1; port_wdata = v;
        @(negedge clk); port_wr_en = 1'b0;
    endtask

    // returns the cycle (1-based) of the first pulse, or -1
    task automatic wait_tc(input int idx, input int maxcyc, output int cyc);
        int k = 0;
        cyc = -1;
        while (k < maxcyc && cyc < 0) begin
            @(negedge clk);
            k++;
            if (tc_pulse[idx]) cyc = k;
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tc", tc_pulse, 0);
        chk("R1 irq", t2_irq, 0);
        chk("R1 dout", dout, 0);
        chk("R1 sel", sel_rdata, 0);
        chk("R1 count", port_rdata, 0);
    endtask

    task automatic t_select;
        wr_sel(8'hA1);
        chk("R11 dout", dout, 4'hA);
        chk("R11 sel_rdata", sel_rdata, 8'hA1);
        wr_sel(8'h05);
        wr_port(16'h1234);
        chk("R9 invalid code reads 0", port_rdata, 0);
        wr_sel(8'h00); chk("R9 t0 untouched", port_rdata, 0);
        wr_sel(8'h01); chk("R9 t1 untouched", port_rdata, 0);
        wr_sel(8'h02); chk("R9 t2 untouched", port_rdata, 0);
    endtask

    task automatic t_clamp;
        wr_sel(8'h00); wr_port(16'd0);
        chk("R8 zero->2", port_rdata, 2);
        wr_sel(8'h01); wr_port(16'd1);
        chk("R8 one->2", port_rdata, 2);
        wr_sel(8'h00); wr_port(16'd7);
        chk("R8 seven kept", port_rdata, 7);
    endtask

    task automatic t_stage;
        wr_sel(8'h02); wr_port(16'h0003);
        chk("R10 lo staged only", port_rdata, 0);
        wr_sel(8'h03); wr_port(16'h00AB);
        chk("R10 upper half", port_rdata, 16'h00AB);
        wr_sel(8'h02);
        chk("R10 lower half", port_rdata, 16'h0003);
    endtask

    task automatic t_prescale;
        wr_mode(8'h00); wr_ctrl(16'h1000); wr_sel(8'h00);
        wr_port(16'd5);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k == 9)  chk("R2 before tick", port_rdata, 5);
            if (k == 10) chk("R2 tick at 10", port_rdata, 4);
        end
        osc_tick = 1'b0;
        repeat (30) @(negedge clk);
        chk("R2 osc stall", port_rdata, 4);
        osc_tick = 1'b1;
        wr_ctrl(16'h0000);
    endtask

    task automatic t_rate;
        int c;
        wr_mode(8'h01); wr_ctrl(16'h1000); wr_sel(8'h00);
        wr_port(16'd3);
        wait_tc(0, 100, c); chk("R3 first pulse", c, 30);
        wait_tc(0, 100, c); chk("R3 period", c, 30);
        wr_ctrl(16'h0000);
        wr_mode(8'h04); wr_ctrl(16'h2000); wr_sel(8'h01);
        wr_port(16'd2);
        wait_tc(1, 3000, c); chk("R13 R2 timer1 rate field", c, 2000);
        wr_ctrl(16'h0000);
    endtask

    task automatic t_term;
        int c;
        wr_mode(8'h00); wr_ctrl(16'h1000); wr_sel(8'h00);
        wr_port(16'd4);
        wait_tc(0, 100, c); chk("R4 pulse", c, 40);
        chk("R4 count zero", port_rdata, 0);
        wait_tc(0, 100, c); chk("R4 no repeat", c, -1);
        wr_ctrl(16'h0000);
    endtask

    task automatic t_swstrobe;
        int c;
        wr_mode(8'h02); wr_ctrl(16'h1000); wr_sel(8'h00);
        wr_port(16'd3);
        wait_tc(0, 100, c); chk("R5 strobe", c, 30);
        chk("R5 reload value", port_rdata, 3);
        wait_tc(0, 80, c); chk("R5 single strobe", c, -1);
        wr_port(16'd5);
        repeat (20) @(negedge clk);
        wr_port(16'd2);
        wait_tc(0, 100, c); chk("R5 restart", c, 20);
        wr_ctrl(16'h0000);
    endtask

    task automatic t_hwstrobe;
        int c;
        wr_mode(8'h03); wr_ctrl(16'h1000); wr_sel(8'h00);
        wr_port(16'd2);
        wait_tc(0, 50, c); chk("R6 waits", c, -1);
        chk("R6 armed count", port_rdata, 2);
        for (int r = 0; r < 2; r++) begin
            @(negedge clk); hw_trig[0] = 1'b1;
            @(negedge clk); hw_trig[0] = 1'b0;
            wait_tc(0, 100, c); chk("R6 triggered strobe", c, 20);
            wait_tc(0, 60, c); chk("R6 rearmed idle", c, -1);
        end
        wr_ctrl(16'h0000);
    endtask

    task automatic t_gate;
        int c;
        wr_mode(8'h01); wr_ctrl(16'hEFFF); wr_sel(8'h00);
        wr_port(16'd3);
        wait_tc(0, 100, c); chk("R7 gate low no pulse", c, -1);
        chk("R7 count frozen", port_rdata, 3);
        wr_ctrl(16'h1000);
        wait_tc(0, 40, c);
        chk("R7 gate high counts", (c > 0 && c <= 30), 1);
        wr_ctrl(16'h0000);
    endtask

    task automatic t_irq;
        int c;
        wr_mode(8'h00); wr_ctrl(16'h4000);
        wr_sel(8'h02); wr_port(16'd2);
        wr_sel(8'h03); wr_port(16'd0);
        wait_tc(2, 3000, c); chk("R12 t2 pulse", c, 2000);
        chk("R12 not yet set", t2_irq, 0);
        @(negedge clk); chk("R12 set", t2_irq, 1);
        repeat (5) @(negedge clk);
        chk("R12 sticky", t2_irq, 1);
        sel_rd_en = 1'b1;
        @(negedge clk); sel_rd_en = 1'b0;
        chk("R12 cleared by read", t2_irq, 0);
        wr_ctrl(16'h0000);
    endtask

    initial begin
        t_reset;
        t_select;
        t_clamp;
        t_stage;
        t_prescale;
        t_rate;
        t_term;
        t_swstrobe;
        t_hwstrobe;
        t_gate;
        t_irq;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule